// File: doc/BRIEF.md
# Split-Fabric Cell Scheduler

This block decides, once per cell time, which queued cells cross a switch whose crossbar has been cut into several smaller crossbars. Every input keeps one virtual output queue per output. The inputs are divided into equal, contiguous groups. Each group owns a private buffer at every output, and each group runs its own request-grant-accept match. Because the groups work independently, one output can take in as many cells in one cell time as there are groups. Each output then drains its buffers at link rate, taking one cell per cell time and cycling through its buffers in round-robin order.

The surrounding queue logic reports which queues hold a cell on `voq_req`. It pops the head cell of every queue flagged on `deq`. The output side writes one cell into each buffer flagged on `buf_wr` and transmits the cell flagged on `buf_rd`. The block sees one clock cycle as one cell time. Random choices come from small shift-register generators with fixed seeds, so the behaviour after reset repeats exactly. With a single group, the block acts as an ordinary one-fabric switch with buffering at both inputs and outputs.

Top module: `xbar_sched`

## Requirements
- R1: `deq` bit `i*N_PORTS+j` (input i, output j) is only set while `voq_req` bit `i*N_PORTS+j` is set in the same cycle.
- R2: At most one `deq` bit is set among the N_PORTS bits that belong to one input in any cycle.
- R3: Input i belongs to group i/(N_PORTS/N_GRP). `buf_wr` bit `j*N_GRP+g` is set exactly when some input of group g is dequeued toward output j. At most one such input exists per cycle.
- R4: Two inputs in different groups that both request the same output, with both buffers non-full, are both dequeued in the same cycle.
- R5: One match iteration runs per cell time. A group that has at least one request to a non-full buffer produces at least one dequeue. An input that is the only requester in its group, and requests only one output, is always dequeued.
- R6: While buffer (j,g) holds BUF_DEPTH cells, no input of group g is dequeued toward output j.
- R7: `buf_rd` has at most one bit set per output, and only for a non-empty buffer. A bit is set whenever any buffer of that output is non-empty. The buffer read is the first non-empty one at or after a pointer. The pointer starts at 0 and moves to the buffer after the one last read.
- R8: After a synchronous reset, all buffers are empty, so `buf_rd` and `buf_wr` are zero, and `deq` is zero while no queue requests.
- R9: With N_GRP = 1, no output receives more than one cell per cell time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one cycle is one cell time |
| rst_n | input | 1 | Synchronous active-low reset |
| voq_req | input | N_PORTS*N_PORTS | Queue non-empty flags, bit i*N_PORTS+j for input i to output j |
| deq | output | N_PORTS*N_PORTS | Head-cell pop strobes, same bit layout as voq_req |
| buf_wr | output | N_PORTS*N_GRP | Buffer write enables, bit j*N_GRP+g for output j, group g |
| buf_rd | output | N_PORTS*N_GRP | Buffer read enables, same layout as buf_wr |

## Verification
The bench targets cases where several groups hit one output at once. A design that let one matcher span all inputs would serve only one of the two requesters, and one that kept groups apart but used the wrong index would write into the wrong group's buffer. It drives one output until its buffers fill. A missing full mask then shows up as a write into a buffer that is already full. It also checks the drain order against a round-robin model. An arbiter that always starts at buffer 0 would starve the higher buffers, and a drain that went idle with data present would break work conservation. Random traffic checks that no matcher ever returns an empty result while it has a valid request, and that no input is popped twice.

// File: rtl/xbar_sched_pkg.sv
// Shared constants for the split-fabric scheduler.
// Assumes the pseudo-random generators are 8 bits wide.
package xbar_sched_pkg;
    localparam int          RND_W    = 8;
    localparam logic [7:0]  RND_TAPS = 8'h1D;  // x^8+x^4+x^3+x^2+1, period 255
endpackage

// File: rtl/rand_pick.sv
// One-of-W picker: grants exactly one set request bit, chosen by a
// rotating start index taken from a free-running shift-register generator.
// Assumes SEED is nonzero; the generator steps on every clock after reset.
module rand_pick
    import xbar_sched_pkg::*;
#(
    parameter int              W    = 4,
    parameter logic [RND_W-1:0] SEED = 8'h01
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] req,
    output logic [W-1:0] gnt
);
    logic [RND_W-1:0] rnd;
    int               start;

    // Advance the generator once per cell time.
    always_ff @(posedge clk) begin
        if (!rst_n) rnd <= SEED;
        else        rnd <= {rnd[RND_W-2:0], 1'b0} ^ ({RND_W{rnd[RND_W-1]}} & RND_TAPS);
    end

    // Grant the requester closest to the random start, scanning upward.
    always_comb begin
        start = int'(rnd) % W;
        for (int i = 0; i < W; i++) begin
            gnt[i] = req[i];
            for (int k = 0; k < W; k++) begin
                if (k != i && req[k] && ((k + W - start) % W) < ((i + W - start) % W))
                    gnt[i] = 1'b0;
            end
        end
    end

    // R2/R3: a picker never grants two requesters.
    assert_pick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    // R5: a picker with any request always grants one.
    assert_pick_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> (|gnt));
endmodule

// File: rtl/pim_group.sv
// Single-iteration request-grant-accept matcher for one input group.
// Each output column grants one requesting input; each input row accepts
// one of its grants. Assumes SEED_BASE is even so every seed is odd.
module pim_group #(
    parameter int N_IN      = 2,
    parameter int N_OUT     = 4,
    parameter int SEED_BASE = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_IN*N_OUT-1:0]  req,
    output logic [N_IN*N_OUT-1:0]  match
);
    logic [N_IN*N_OUT-1:0] gnt_mat;

    // Grant stage: one picker per output over the group's inputs.
    for (genvar j = 0; j < N_OUT; j++) begin : g_grant
        logic [N_IN-1:0] col_req, col_gnt;
        for (genvar i = 0; i < N_IN; i++) begin : g_col
            assign col_req[i]          = req[i*N_OUT+j];
            assign gnt_mat[i*N_OUT+j]  = col_gnt[i];
        end
        rand_pick #(.W(N_IN), .SEED(8'((SEED_BASE + 2*j + 1) % 256))) u_gpick (
            .clk(clk), .rst_n(rst_n), .req(col_req), .gnt(col_gnt));
    end

    // Accept stage: one picker per input over the grants it received.
    for (genvar i = 0; i < N_IN; i++) begin : g_accept
        rand_pick #(.W(N_OUT), .SEED(8'((SEED_BASE + 2*N_OUT + 2*i + 1) % 256))) u_apick (
            .clk(clk), .rst_n(rst_n), .req(gnt_mat[i*N_OUT +: N_OUT]),
            .gnt(match[i*N_OUT +: N_OUT]));
    end

    // R1: a match always rests on a request of the same pair.
    assert_match_requested_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (match & ~req) == '0);
endmodule

// File: rtl/out_port.sv
// Buffer bookkeeping for one output: one occupancy counter per group buffer
// and a round-robin drain of one cell per cell time. Assumes the writer
// never writes a full buffer (the scheduler masks such requests).
module out_port #(
    parameter int K     = 2,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [K-1:0] wr,
    output logic [K-1:0] rd,
    output logic [K-1:0] full
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int PW = (K > 1) ? $clog2(K) : 1;

    logic [CW-1:0] cnt [K];
    logic [PW-1:0] ptr, nxt_ptr;
    logic [K-1:0]  busy;

    // Decode empty/full per buffer.
    always_comb begin
        for (int b = 0; b < K; b++) begin
            busy[b] = (cnt[b] != '0);
            full[b] = (cnt[b] == CW'(DEPTH));
        end
    end

    // Pick the first non-empty buffer at or after the pointer.
    always_comb begin
        for (int b = 0; b < K; b++) begin
            rd[b] = busy[b];
            for (int k = 0; k < K; k++) begin
                if (k != b && busy[k] &&
                    ((k + K - int'(ptr)) % K) < ((b + K - int'(ptr)) % K))
                    rd[b] = 1'b0;
            end
        end
    end

    // Move the pointer past the buffer just read.
    always_comb begin
        nxt_ptr = ptr;
        for (int b = 0; b < K; b++)
            if (rd[b]) nxt_ptr = PW'((b + 1) % K);
    end

    // Update occupancy and pointer once per cell time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < K; b++) cnt[b] <= '0;
            ptr <= '0;
        end else begin
            for (int b = 0; b < K; b++) cnt[b] <= cnt[b] + CW'(wr[b]) - CW'(rd[b]);
            ptr <= nxt_ptr;
        end
    end

    for (genvar b = 0; b < K; b++) begin : g_chk
        // R6: a full buffer is never written.
        assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
            full[b] |-> !wr[b]);
        // R7: an empty buffer is never read.
        assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
            rd[b] |-> busy[b]);
    end
    // R7: one read per cell time, and never idle with data present.
    assert_one_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd));
    assert_work_conserving_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|busy) |-> (|rd));
endmodule

// File: rtl/xbar_sched.sv
// Split-fabric cell scheduler top. Inputs are cut into N_GRP contiguous
// groups; each group matches on its own against its private buffer at
// every output, and each output drains its buffers round-robin.
// Assumes N_GRP divides N_PORTS and one clock is one cell time.
module xbar_sched #(
    parameter int N_PORTS   = 4,
    parameter int N_GRP     = 2,
    parameter int BUF_DEPTH = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_PORTS*N_PORTS-1:0]   voq_req,
    output logic [N_PORTS*N_PORTS-1:0]   deq,
    output logic [N_PORTS*N_GRP-1:0]     buf_wr,
    output logic [N_PORTS*N_GRP-1:0]     buf_rd
);
    localparam int GSZ = N_PORTS / N_GRP;

    logic [N_PORTS*N_GRP-1:0] full_all;

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        logic [GSZ*N_PORTS-1:0] rq, mt;

        // Mask each request by the full flag of the group's buffer there.
        for (genvar il = 0; il < GSZ; il++) begin : g_in
            for (genvar j = 0; j < N_PORTS; j++) begin : g_out
                assign rq[il*N_PORTS+j] =
                    voq_req[(g*GSZ+il)*N_PORTS+j] & ~full_all[j*N_GRP+g];
                assign deq[(g*GSZ+il)*N_PORTS+j] = mt[il*N_PORTS+j];
            end
        end

        pim_group #(.N_IN(GSZ), .N_OUT(N_PORTS), .SEED_BASE(40*g)) u_match (
            .clk(clk), .rst_n(rst_n), .req(rq), .match(mt));

        // Write the group's buffer at an output when the group sent it a cell.
        for (genvar j = 0; j < N_PORTS; j++) begin : g_wr
            logic hit;
            always_comb begin
                hit = 1'b0;
                for (int il = 0; il < GSZ; il++) hit = hit | mt[il*N_PORTS+j];
            end
            assign buf_wr[j*N_GRP+g] = hit;
        end
    end

    for (genvar j = 0; j < N_PORTS; j++) begin : g_port
        out_port #(.K(N_GRP), .DEPTH(BUF_DEPTH)) u_port (
            .clk(clk), .rst_n(rst_n),
            .wr(buf_wr[j*N_GRP +: N_GRP]),
            .rd(buf_rd[j*N_GRP +: N_GRP]),
            .full(full_all[j*N_GRP +: N_GRP]));
    end

    // R1: pops only for queues that hold a cell.
    assert_deq_has_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (deq & ~voq_req) == '0);
    for (genvar i = 0; i < N_PORTS; i++) begin : g_in_chk
        // R2: one cell leaves an input per cell time.
        assert_one_per_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(deq[i*N_PORTS +: N_PORTS]));
    end
endmodule

// File: tb/xbar_sched_tb.sv
`timescale 1ns/1ps
module xbar_sched_tb;
    localparam int N = 4;
    localparam int K = 2;
    localparam int D = 2;
    localparam int G = N / K;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N*N-1:0]  voq_req = '0;
    logic [N*N-1:0]  deq, deq1;
    logic [N*K-1:0]  buf_wr, buf_rd;
    logic [N-1:0]    buf_wr1, buf_rd1;

    int tests = 0;
    int fails = 0;
    int cnt [N][K];
    int ptr [N];
    bit full_seen = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    xbar_sched #(.N_PORTS(N), .N_GRP(K), .BUF_DEPTH(D)) u_dut (
        .clk(clk), .rst_n(rst_n), .voq_req(voq_req),
        .deq(deq), .buf_wr(buf_wr), .buf_rd(buf_rd));

    xbar_sched #(.N_PORTS(N), .N_GRP(1), .BUF_DEPTH(D)) u_dut_k1 (
        .clk(clk), .rst_n(rst_n), .voq_req(voq_req),
        .deq(deq1), .buf_wr(buf_wr1), .buf_rd(buf_rd1));

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected round-robin read mask of output j from the model.
    function automatic logic [K-1:0] exp_rd(input int j);
        exp_rd = '0;
        for (int d = 0; d < K; d++) begin
            int b;
            b = (ptr[j] + d) % K;
            if (exp_rd == '0 && cnt[j][b] > 0) exp_rd[b] = 1'b1;
        end
    endfunction

    // Drive one cell time, check every rule, then advance the model.
    task automatic step(input logic [N*N-1:0] v);
        logic [K-1:0] erd [N];
        @(negedge clk);
        voq_req = v;
        #1;
        chk((deq & ~v) == '0, "R1 pop without request", deq, v);
        for (int i = 0; i < N; i++)
            chk($countones(deq[i*N +: N]) <= 1, "R2 input popped twice", deq[i*N +: N], 0);
        for (int j = 0; j < N; j++) begin
            int c1;
            c1 = 0;
            for (int i = 0; i < N; i++) c1 += deq1[i*N+j];
            chk(c1 <= 1, "R9 single fabric output took two cells", c1, 1);
            for (int g = 0; g < K; g++) begin
                int c;
                bit elig;
                c = 0;
                elig = 1'b0;
                for (int il = 0; il < G; il++) c += deq[(g*G+il)*N+j];
                chk(c <= 1 && buf_wr[j*K+g] == (c == 1), "R3 group buffer write",
                    buf_wr[j*K+g], c);
                if (cnt[j][g] == D) begin
                    for (int il = 0; il < G; il++) if (v[(g*G+il)*N+j]) full_seen = 1'b1;
                    chk(c == 0, "R6 write into full buffer", c, 0);
                end
                elig = 1'b0;
                for (int il = 0; il < G; il++) if (v[(g*G+il)*N+j]) elig = 1'b1;
                if (elig && cnt[j][g] < D) begin
                    int gc;
                    gc = 0;
                    for (int il = 0; il < G; il++) gc += $countones(deq[(g*G+il)*N +: N]);
                    chk(gc >= 1, "R5 group with request made no match", gc, 1);
                end
            end
            erd[j] = exp_rd(j);
            chk(buf_rd[j*K +: K] == erd[j], "R7 drain order", buf_rd[j*K +: K], erd[j]);
        end
        for (int j = 0; j < N; j++) begin
            for (int g = 0; g < K; g++) cnt[j][g] += int'(buf_wr[j*K+g]) - int'(erd[j][g]);
            for (int g = 0; g < K; g++) if (erd[j][g]) ptr[j] = (g + 1) % K;
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int unused;
        unused = $urandom(32'd1234);
        for (int j = 0; j < N; j++) begin
            ptr[j] = 0;
            for (int g = 0; g < K; g++) cnt[j][g] = 0;
        end
        // R8: reset state.
        repeat (3) @(negedge clk);
        #1;
        chk(buf_rd == '0, "R8 read after reset", buf_rd, 0);
        chk(buf_wr == '0, "R8 write after reset", buf_wr, 0);
        chk(deq == '0, "R8 pop after reset", deq, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R5: lone requester, input 1 to output 3.
        step(16'(1) << (1*N+3));
        chk(deq == (16'(1) << (1*N+3)), "R5 lone requester", deq, 16'(1) << (1*N+3));

        // R4: inputs 0 and 2 (different groups) both to output 1.
        step((16'(1) << (0*N+1)) | (16'(1) << (2*N+1)));
        chk(deq == ((16'(1) << (0*N+1)) | (16'(1) << (2*N+1))), "R4 both groups served",
            deq, (16'(1) << (0*N+1)) | (16'(1) << (2*N+1)));
        chk(buf_wr[1*K +: K] == 2'b11, "R3 both buffers of output 1", buf_wr[1*K +: K], 2'b11);
        chk($countones(deq1) == 1, "R9 single fabric serves one", $countones(deq1), 1);

        // R6: every input hammers output 0 until its buffers fill.
        repeat (8) step(16'h1111);
        chk(full_seen, "R6 full buffer reached", full_seen, 1);

        // R7: idle inputs, buffers drain round-robin.
        repeat (6) step('0);
        chk(buf_rd == '0, "R7 drained to empty", buf_rd, 0);

        // Random traffic mixed with dense bursts.
        for (int n = 0; n < 3000; n++) begin
            if (n % 97 == 0) step('1);
            else             step(16'($urandom & $urandom));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule